// File: doc/BRIEF.md
# Programmable Priority Arbiter with Latency Escalation

This block arbitrates four requesters competing for a single target port of an on-chip interconnect. The requesters are a CPU buffer (index 0), a DMA engine (index 1), a bus bridge (index 2) and an external-bus target (index 3). Each requester has a request/grant handshake. A grant, once given, stays with its owner until the owner drops its request. Only one grant is active at a time.

After reset the arbiter works as a fixed-priority arbiter. Its default order is CPU buffer first, then the external-bus target, then the DMA engine, then the bus bridge. Software can change the priority of every requester through a small register port.

The DMA, bridge and external requesters each have a wait counter that software can switch on. When a switched-on counter shows that a pending request has waited its programmed maximum number of cycles, that request is served ahead of the normal order. This keeps even the lowest-priority requester from waiting forever.

Top module: `prio_lat_arb`

## Requirements
- R1: After reset no grant is active, and the priority values are CPU=0, DMA=2, bridge=3, external=1. All latency enables and all maximum latencies are zero. A lower priority value means higher priority.
- R2: The register map is as follows. Address 0 is the latency enable register: bit 0 is DMA, bit 1 is bridge, bit 2 is external, and all other bits read as zero. Address 1 is the CPU priority in bits [3:0]. Addresses 2, 3 and 4 are the DMA, bridge and external configuration words, each with priority in bits [3:0] and maximum latency in bits [23:16]. Reserved bits read as zero, and reads are combinational.
- R3: When no grant is held and at least one request is high, exactly one grant appears on the next clock edge. It goes to the requesting index with the lowest priority value, and equal values go to the lower index.
- R4: At most one grant is active at a time. A grant stays unchanged while its owner keeps requesting, whatever the other requesters do. The grant is removed on the first edge after the owner's request is seen low.
- R5: An enabled wait counter counts the clock edges during which its request is high and not granted. It saturates at the programmed maximum and clears whenever the request is not pending.
- R6: A requester whose enabled counter has reached its maximum is expired. Expired requesters are served before all non-expired ones at the next arbitration.
- R7: Among several expired requesters, the lowest priority value wins, and equal values go to the lower index.
- R8: A requester whose latency enable is off is never escalated, however long it waits. The CPU has no latency counter at all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 4 | Request per requester (0 CPU, 1 DMA, 2 bridge, 3 external) |
| gnt | output | 4 | One-hot grant per requester |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data |

## Verification
The bench builds the block with its default widths: 4-bit priority fields, 8-bit latency counters and a 3-bit register address. Four requesters make an exhaustive sweep of all sixteen request patterns practical under ten priority assignments, including full ties and paired ties, as well as the reset order. Sweeping the wait length from zero to seven cycles, with maximum latencies of 3 and 5, crosses each counter's expiry boundary and the point where two requesters expire together. The same run also shows the effect of a cleared enable bit.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int NREQ      = 4;
  localparam int R_CPU     = 0;
  localparam int R_DMA     = 1;
  localparam int R_BRG     = 2;
  localparam int R_EXT     = 3;
  localparam int A_LATEN   = 0;
  localparam int A_CPUPRI  = 1;
  localparam int A_CFGBASE = 2;
  localparam int LAT_LSB   = 16;

  // Reset order: CPU, external, DMA, bridge
  function automatic int reset_prio(int idx);
    case (idx)
      R_CPU:   return 0;
      R_EXT:   return 1;
      R_DMA:   return 2;
      default: return 3;
    endcase
  endfunction
endpackage

// File: rtl/arb_cfg.sv
module arb_cfg
  import arb_pkg::*;
#(
  parameter int PRIO_W = 4,
  parameter int LAT_W  = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [DATA_W-1:0]                 wdata,
  output logic [DATA_W-1:0]                 rdata,
  output logic [NREQ-1:0][PRIO_W-1:0]       prio,
  output logic [NREQ-1:0][LAT_W-1:0]        max_lat,
  output logic [NREQ-1:0]                   lat_en
);
  localparam int NLAT = NREQ - 1;

  logic [NREQ-1:0][PRIO_W-1:0] prio_q, prio_d;
  logic [NREQ-1:0][LAT_W-1:0]  max_q, max_d;
  logic [NLAT-1:0]             en_q, en_d;

  always_comb begin
    prio_d = prio_q;
    max_d  = max_q;
    en_d   = en_q;
    if (wr) begin
      if (addr == ADDR_W'(A_LATEN)) en_d = wdata[NLAT-1:0];
      if (addr == ADDR_W'(A_CPUPRI)) prio_d[R_CPU] = wdata[PRIO_W-1:0];
      for (int i = 1; i < NREQ; i++) begin
        if (addr == ADDR_W'(A_CFGBASE + i - 1)) begin
          prio_d[i] = wdata[PRIO_W-1:0];
          max_d[i]  = wdata[LAT_LSB +: LAT_W];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREQ; i++) begin
        prio_q[i] <= PRIO_W'(reset_prio(i));
        max_q[i]  <= '0;
      end
      en_q <= '0;
    end else if (wr) begin
      prio_q <= prio_d;
      max_q  <= max_d;
      en_q   <= en_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(A_LATEN)) rdata[NLAT-1:0] = en_q;
    if (addr == ADDR_W'(A_CPUPRI)) rdata[PRIO_W-1:0] = prio_q[R_CPU];
    for (int i = 1; i < NREQ; i++) begin
      if (addr == ADDR_W'(A_CFGBASE + i - 1)) begin
        rdata[PRIO_W-1:0]          = prio_q[i];
        rdata[LAT_LSB +: LAT_W]    = max_q[i];
      end
    end
  end

  assign prio    = prio_q;
  assign max_lat = max_q;
  assign lat_en  = {en_q, 1'b0};
endmodule

// File: rtl/arb_lat_cnt.sv
module arb_lat_cnt #(
  parameter int LAT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             pending,
  input  logic [LAT_W-1:0] max_lat,
  output logic             expired
);
  logic [LAT_W-1:0] cnt_q, cnt_d;
  logic             run;

  assign run = en & pending;

  always_comb begin
    cnt_d = cnt_q;
    if (!run)                 cnt_d = '0;
    else if (cnt_q < max_lat) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = run & (cnt_q >= max_lat);

  // R5: an idle or disabled counter is back at zero one edge later
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));
  // R8: a disabled counter never reports expiry
  p_off_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !expired);
endmodule

// File: rtl/arb_pick.sv
module arb_pick
  import arb_pkg::*;
#(
  parameter int PRIO_W = 4
) (
  input  logic [NREQ-1:0]             req,
  input  logic [NREQ-1:0]             expired,
  input  logic [NREQ-1:0][PRIO_W-1:0] prio,
  output logic [NREQ-1:0]             win
);
  logic [NREQ-1:0]   cand;
  logic [PRIO_W-1:0] best;
  logic              found;

  always_comb begin
    cand  = (|(req & expired)) ? (req & expired) : req;
    best  = '1;
    found = 1'b0;
    win   = '0;
    for (int i = 0; i < NREQ; i++) begin
      if (cand[i] && (!found || prio[i] < best)) begin
        found  = 1'b1;
        best   = prio[i];
        win    = '0;
        win[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/prio_lat_arb.sv
module prio_lat_arb
  import arb_pkg::*;
#(
  parameter int PRIO_W = 4,
  parameter int LAT_W  = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NREQ-1:0]   req,
  output logic [NREQ-1:0]   gnt,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [NREQ-1:0][PRIO_W-1:0] prio;
  logic [NREQ-1:0][LAT_W-1:0]  max_lat;
  logic [NREQ-1:0]             lat_en;
  logic [NREQ-1:0]             expired;
  logic [NREQ-1:0]             win;
  logic [NREQ-1:0]             gnt_q, gnt_d;
  logic                        held;

  arb_cfg #(.PRIO_W(PRIO_W), .LAT_W(LAT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_cfg (
    .clk(clk), .rst_n(rst_int_n), .wr(cfg_wr), .addr(cfg_addr), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .prio(prio), .max_lat(max_lat), .lat_en(lat_en)
  );

  assign expired[R_CPU] = 1'b0;
  for (genvar g = 1; g < NREQ; g++) begin : g_lat
    arb_lat_cnt #(.LAT_W(LAT_W)) i_cnt (
      .clk(clk), .rst_n(rst_int_n), .en(lat_en[g]),
      .pending(req[g] & ~gnt_q[g]), .max_lat(max_lat[g]), .expired(expired[g])
    );
  end

  arb_pick #(.PRIO_W(PRIO_W)) i_pick (
    .req(req), .expired(expired), .prio(prio), .win(win)
  );

  assign held = |(gnt_q & req);

  always_comb begin
    gnt_d = held ? gnt_q : win;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) gnt_q <= '0;
    else            gnt_q <= gnt_d;
  end

  assign gnt = gnt_q;

  // R4: never more than one grant
  p_onehot_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0(gnt_q));
  // R4: a grant whose owner still requests does not move
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    held |=> (gnt_q == $past(gnt_q)));
  // R3: a free port with a pending request grants on the next edge
  p_no_idle_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!held && |req) |=> (|gnt_q));
  // R3: a fresh grant always goes to a requester that asked
  p_fresh_to_req_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!held) |=> ((gnt_q & ~$past(req)) == '0));
  // R6: an expired requester beats every non-expired one
  p_expired_first_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!held && |(expired & req)) |=> (|(gnt_q & $past(expired))));
endmodule

// File: tb/test_prio_lat_arb.sv
module test_prio_lat_arb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  req;
  logic [3:0]  gnt;
  logic        cfg_wr;
  logic [2:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;

  int checks = 0;
  int errors = 0;
  int pr[4];
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_lat_arb i_prio_lat_arb (
    .clk(clk), .rst_n(rst_n), .req(req), .gnt(gnt),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd(string tag, logic [2:0] a, logic [31:0] exp);
    @(negedge clk);
    cfg_addr = a;
    #1 chk(tag, cfg_rdata, exp);
  endtask

  task automatic load_cfg(int m1, int m2, int m3);
    wr(3'd1, 32'(pr[0]));
    wr(3'd2, 32'((m1 << 16) | pr[1]));
    wr(3'd3, 32'((m2 << 16) | pr[2]));
    wr(3'd4, 32'((m3 << 16) | pr[3]));
  endtask

  function automatic logic [3:0] model(logic [3:0] r, logic [3:0] ex);
    logic [3:0] cand, w;
    int best;
    cand = (|(r & ex)) ? (r & ex) : r;
    w = '0; best = 99;
    for (int i = 0; i < 4; i++)
      if (cand[i] && pr[i] < best) begin best = pr[i]; w = '0; w[i] = 1'b1; end
    return w;
  endfunction

  task automatic sweep_patterns(string tag);
    for (int p = 0; p < 16; p++) begin
      @(negedge clk); req = 4'(p);
      @(posedge clk); @(negedge clk);
      chk({tag, " R3 winner"}, 32'(gnt), 32'(model(4'(p), 4'b0)));
      req = 4'b0;
      @(posedge clk); @(negedge clk);
      chk({tag, " R4 release"}, 32'(gnt), 32'h0);
    end
  endtask

  // CPU holds the port for w edges while DMA, bridge and external wait
  task automatic wait_then_release(int w, logic [3:0] ex, string tag);
    @(negedge clk); req = 4'b0001;
    @(posedge clk); @(negedge clk);
    if (w == 0) req = 4'b1110;
    else begin
      req = 4'b1111;
      repeat (w) @(posedge clk);
      @(negedge clk); req = 4'b1110;
    end
    @(posedge clk); @(negedge clk);
    chk(tag, 32'(gnt), 32'(model(4'b1110, ex)));
    req = 4'b0;
    @(posedge clk); @(posedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R4 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req = '0; cfg_wr = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: reset state
    @(negedge clk);
    chk("R1 no grant", 32'(gnt), 32'h0);
    rd("R1 enables", 3'd0, 32'h0);
    rd("R1 cpu prio", 3'd1, 32'h0);
    rd("R1 dma cfg", 3'd2, 32'h2);
    rd("R1 bridge cfg", 3'd3, 32'h3);
    rd("R1 ext cfg", 3'd4, 32'h1);

    // R2: readback masks reserved bits
    wr(3'd0, 32'hFFFF_FFFF); rd("R2 enable mask", 3'd0, 32'h7);
    wr(3'd2, 32'hFFFF_FFFF); rd("R2 cfg mask", 3'd2, 32'h00FF_000F);
    wr(3'd1, 32'hFFFF_FFF5); rd("R2 cpu mask", 3'd1, 32'h5);
    rd("R2 unmapped", 3'd6, 32'h0);
    wr(3'd0, 32'h0);

    // R1/R3: default order over all patterns
    pr = '{0, 2, 3, 1};
    load_cfg(0, 0, 0);
    sweep_patterns("default");

    // R3: permuted, tied and paired-tie priorities
    for (int k = 1; k <= 3; k += 2)
      for (int off = 0; off < 4; off++) begin
        for (int i = 0; i < 4; i++) pr[i] = (i * k + off) % 4;
        load_cfg(0, 0, 0);
        sweep_patterns("perm");
      end
    pr = '{5, 5, 5, 5}; load_cfg(0, 0, 0); sweep_patterns("tie");
    pr = '{1, 1, 0, 0}; load_cfg(0, 0, 0); sweep_patterns("pairtie");

    // R4: hold against higher-priority arrivals
    pr = '{0, 2, 3, 1}; load_cfg(0, 0, 0);
    @(negedge clk); req = 4'b0100;
    @(posedge clk); @(negedge clk);
    chk("R4 bridge granted", 32'(gnt), 32'h4);
    req = 4'b1111;
    for (int c = 0; c < 3; c++) begin
      @(posedge clk); @(negedge clk);
      chk("R4 hold", 32'(gnt), 32'h4);
    end
    req = 4'b1011;
    @(posedge clk); @(negedge clk);
    chk("R4 handover to cpu", 32'(gnt), 32'h1);
    req = 4'b0;
    @(posedge clk); @(posedge clk);

    // R5/R6/R7: bridge max 3, external max 5, both enabled
    pr = '{0, 2, 3, 1}; load_cfg(0, 3, 5);
    wr(3'd0, 32'h6);
    for (int w = 0; w < 8; w++)
      wait_then_release(w, {w >= 5, w >= 3, 2'b00}, "R6 expiry sweep");

    // R8: enables off, long wait, no escalation
    wr(3'd0, 32'h0);
    wait_then_release(6, 4'b0000, "R8 disabled");

    // R7: two expired with equal priority, lower index wins
    pr = '{0, 2, 3, 3}; load_cfg(0, 2, 2);
    wr(3'd0, 32'h6);
    wait_then_release(4, 4'b1100, "R7 expired tie");
    pr = '{0, 2, 3, 1}; load_cfg(0, 2, 2);
    wait_then_release(4, 4'b1100, "R7 expired order");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule